// File: doc/BRIEF.md
# Unstable AND-Merge Accumulator Path

This unit models, cycle by cycle, how an 8-bit processor's accumulator is updated when it runs the undocumented opcode that merges A, X and an immediate byte. The accumulator drives the internal bus and is written from that same bus, so competing drivers resolve as a wired-AND. A per-device constant, `MAGIC`, selects which bits of the old accumulator value are forced high before the AND.

A bus latch is precharged to all ones when an operation starts. It then ANDs in the data bus on every clock while the operation is in progress, including cycles in which `rdy` holds the processor stalled. As a result, stray bus values seen during a stall end up in the result. The operation ends at the first clock with `rdy` high. On that edge A takes the merged value and the N and Z flags follow it. A parameter selects the device variant that drops bit 4 of the result whenever a stall has occurred.

Software does not see this block. A surrounding core model loads A and X through the load ports, pulses `start` in the cycle before the operand cycle, and waits for `done`.

Top module: `xaa_merge_unit`

## Requirements
- R1: After reset, `a_out`, `n_flag`, `z_flag` and `done` are 0, and the X register is 0. An operation run with A loaded to 0xFF, X not loaded and operand 0xFF therefore returns 0x00 with Z set.
- R2: With no stall, the result is (A | MAGIC) & X & operand. The operand is the `data_in` value in the clock where `rdy` is high.
- R3: `done` goes high for exactly one cycle, in the cycle after the clock edge at which the busy unit first sees `rdy` high.
- R4: Every `data_in` value sampled while busy with `rdy` low is also ANDed into the result.
- R5: If `RDY_CLR_B4` is 1 and at least one stall cycle occurred, result bit 4 is forced to 0. If `RDY_CLR_B4` is 0, bit 4 follows the formula.
- R6: At completion, `n_flag` equals result bit 7 and `z_flag` is 1 exactly when the result is zero. The flags change at no other time.
- R7: While an operation is in progress, `start`, `a_wr` and `x_wr` have no effect.
- R8: `a_out` keeps its old value through every stall cycle and changes only at completion, or on a load while idle.
- R9: With `MAGIC` = 0x00, the result is the plain AND of A, X and the operand, together with any stall values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one bus sample point |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation; the operand cycle follows |
| rdy | input | 1 | High ends the operation; low stalls it |
| data_in | input | 8 | External data bus |
| a_wr | input | 1 | Load A from `a_wdata` while idle |
| a_wdata | input | 8 | Accumulator load value |
| x_wr | input | 1 | Load X from `x_wdata` while idle |
| x_wdata | input | 8 | X register load value |
| a_out | output | 8 | Accumulator |
| n_flag | output | 1 | Negative flag |
| z_flag | output | 1 | Zero flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker checks, on every cycle, the invariants that hold whatever the data is. These are: the single-cycle `done` pulse after the completing edge, the accumulator holding through stalls, flags that agree with `a_out` and change only at completion, result bits appearing only where X is set, the latch only losing ones, and bit 4 clear after a stall. Only the bench scenarios can show the data values. That covers the exact merge with each `MAGIC`, the contribution of each stray stall value, and the fact that `start` and load requests arriving during a stall are discarded. The bench compares against its own bit-wise model for a table of vectors, a random sweep without stalls, and random stall lengths with random bus values.

// File: rtl/xaa_pkg.sv
package xaa_pkg;
  localparam int unsigned XAA_W         = 8;
  localparam int unsigned XAA_STALL_BIT = 4;

  typedef logic [XAA_W-1:0] xaa_word_t;

  // Wired-AND merge: magic bits of the old A are forced high, strip bits dropped.
  function automatic xaa_word_t xaa_merge(input xaa_word_t acc,
                                          input xaa_word_t xreg,
                                          input xaa_word_t bus_and,
                                          input xaa_word_t magic,
                                          input xaa_word_t strip);
    return (acc | magic) & xreg & bus_and & ~strip;
  endfunction

  function automatic logic xaa_is_zero(input xaa_word_t v);
    return (v == '0);
  endfunction

  function automatic logic xaa_is_neg(input xaa_word_t v);
    return v[XAA_W-1];
  endfunction
endpackage

// File: rtl/xaa_seq_ctrl.sv
module xaa_seq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rdy,
  output logic accept,
  output logic busy,
  output logic fire,
  output logic stall_seen,
  output logic done
);
  logic busy_q, stall_q, done_q;

  assign accept     = start & ~busy_q;
  assign fire       = busy_q & rdy;
  assign busy       = busy_q;
  assign stall_seen = stall_q;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      stall_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire;
      if (accept) begin
        busy_q  <= 1'b1;
        stall_q <= 1'b0;
      end else if (fire) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        stall_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xaa_bus_latch.sv
module xaa_bus_latch
  import xaa_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      precharge,
  input  logic      sample,
  input  xaa_word_t data_in,
  output xaa_word_t latch_q,
  output xaa_word_t bus_and
);
  xaa_word_t lat;

  assign latch_q = lat;
  assign bus_and = lat & data_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lat <= '0;
    else if (precharge) lat <= '1;
    else if (sample)    lat <= lat & data_in;
  end
endmodule

// File: rtl/xaa_acc_regs.sv
module xaa_acc_regs
  import xaa_pkg::*;
#(
  parameter xaa_word_t MAGIC      = 8'hEE,
  parameter bit        RDY_CLR_B4 = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idle,
  input  logic      fire,
  input  logic      stall_seen,
  input  xaa_word_t bus_and,
  input  logic      a_wr,
  input  xaa_word_t a_wdata,
  input  logic      x_wr,
  input  xaa_word_t x_wdata,
  output xaa_word_t a_q,
  output xaa_word_t x_q,
  output logic      n_q,
  output logic      z_q
);
  localparam xaa_word_t STALL_STRIP = xaa_word_t'(1) << XAA_STALL_BIT;

  xaa_word_t strip, a_next;
  xaa_word_t a_r, x_r;
  logic      n_r, z_r;

  generate
    if (RDY_CLR_B4) begin : g_strip_on
      assign strip = stall_seen ? STALL_STRIP : '0;
    end else begin : g_strip_off
      assign strip = '0;
    end
  endgenerate

  assign a_next = xaa_merge(a_r, x_r, bus_and, MAGIC, strip);
  assign a_q = a_r;
  assign x_q = x_r;
  assign n_q = n_r;
  assign z_q = z_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_r <= '0;
      x_r <= '0;
      n_r <= 1'b0;
      z_r <= 1'b0;
    end else begin
      if (fire) begin
        a_r <= a_next;
        n_r <= xaa_is_neg(a_next);
        z_r <= xaa_is_zero(a_next);
      end else if (idle && a_wr) begin
        a_r <= a_wdata;
      end
      if (idle && x_wr) x_r <= x_wdata;
    end
  end
endmodule

// File: rtl/xaa_merge_unit.sv
module xaa_merge_unit
  import xaa_pkg::*;
#(
  parameter logic [7:0] MAGIC      = 8'hEE,
  parameter bit         RDY_CLR_B4 = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rdy,
  input  logic [7:0] data_in,
  input  logic       a_wr,
  input  logic [7:0] a_wdata,
  input  logic       x_wr,
  input  logic [7:0] x_wdata,
  output logic [7:0] a_out,
  output logic       n_flag,
  output logic       z_flag,
  output logic       done
);
  logic      accept, busy, fire, stall_seen;
  xaa_word_t latch_q, bus_and, x_q;

  xaa_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .rdy(rdy),
    .accept(accept), .busy(busy), .fire(fire),
    .stall_seen(stall_seen), .done(done)
  );

  xaa_bus_latch u_latch (
    .clk(clk), .rst_n(rst_n), .precharge(accept), .sample(busy),
    .data_in(data_in), .latch_q(latch_q), .bus_and(bus_and)
  );

  xaa_acc_regs #(.MAGIC(MAGIC), .RDY_CLR_B4(RDY_CLR_B4)) u_acc (
    .clk(clk), .rst_n(rst_n), .idle(~busy), .fire(fire),
    .stall_seen(stall_seen), .bus_and(bus_and),
    .a_wr(a_wr), .a_wdata(a_wdata), .x_wr(x_wr), .x_wdata(x_wdata),
    .a_q(a_out), .x_q(x_q), .n_q(n_flag), .z_q(z_flag)
  );
endmodule

// File: rtl/xaa_merge_chk.sv
module xaa_merge_chk
  import xaa_pkg::*;
#(
  parameter bit RDY_CLR_B4 = 1'b1
) (
  input logic      clk,
  input logic      rst_n,
  input logic      rdy,
  input logic      busy,
  input logic      fire,
  input logic      stall_seen,
  input xaa_word_t latch_q,
  input xaa_word_t x_q,
  input xaa_word_t a_out,
  input logic      n_flag,
  input logic      z_flag,
  input logic      done
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_FIRE_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n) fire |=> done); // R3
  AST_A_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n) (busy && !rdy) |=> $stable(a_out)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy && !rdy) |=> busy); // R7
  AST_FLAG_N: assert property (@(posedge clk) disable iff (!rst_n) done |-> (n_flag == a_out[XAA_W-1])); // R6
  AST_FLAG_Z: assert property (@(posedge clk) disable iff (!rst_n) done |-> (z_flag == (a_out == '0))); // R6
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !fire |=> ($stable(n_flag) && $stable(z_flag))); // R6
  AST_X_SUBSET: assert property (@(posedge clk) disable iff (!rst_n) fire |=> ((a_out & ~$past(x_q)) == '0)); // R2
  AST_LATCH_SHRINK: assert property (@(posedge clk) disable iff (!rst_n) busy |=> ((latch_q & ~$past(latch_q)) == '0)); // R4

  generate
    if (RDY_CLR_B4) begin : g_b4
      AST_B4_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) (done && stall_seen) |-> !a_out[XAA_STALL_BIT]); // R5
    end
  endgenerate
endmodule

bind xaa_merge_unit xaa_merge_chk #(.RDY_CLR_B4(RDY_CLR_B4)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .busy(busy), .fire(fire),
  .stall_seen(stall_seen), .latch_q(latch_q), .x_q(x_q),
  .a_out(a_out), .n_flag(n_flag), .z_flag(z_flag), .done(done)
);

// File: tb/test_xaa_merge_unit.sv
module test_xaa_merge_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, rdy = 1'b1, a_wr = 1'b0, x_wr = 1'b0;
  logic [7:0] data_in = 8'h00, a_wdata = 8'h00, x_wdata = 8'h00;
  logic [7:0] a0, a1;
  logic       n0, z0, d0, n1, z1, d1;

  int checks = 0;
  int fails  = 0;
  logic [7:0] ra0, ra1, rx;   // bench model of A (both variants) and X

  always #2.5 clk = ~clk;

  xaa_merge_unit #(.MAGIC(8'hEE), .RDY_CLR_B4(1'b1)) i_xaa_merge_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .rdy(rdy), .data_in(data_in),
    .a_wr(a_wr), .a_wdata(a_wdata), .x_wr(x_wr), .x_wdata(x_wdata),
    .a_out(a0), .n_flag(n0), .z_flag(z0), .done(d0));

  xaa_merge_unit #(.MAGIC(8'h00), .RDY_CLR_B4(1'b0)) i_xaa_merge_unit_m0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rdy(rdy), .data_in(data_in),
    .a_wr(a_wr), .a_wdata(a_wdata), .x_wr(x_wr), .x_wdata(x_wdata),
    .a_out(a1), .n_flag(n1), .z_flag(z1), .done(d1));

  // {A, X, operand, expected result for MAGIC=0xEE}
  localparam logic [31:0] VEC [8] = '{
    32'h00_FF_FF_EE, 32'hFF_FF_FF_FF, 32'h11_FF_FF_FF, 32'h00_0F_FF_0E,
    32'h01_FF_F0_E0, 32'hFF_00_FF_00, 32'h10_3C_5A_18, 32'h00_81_FF_80 };

  function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] x,
                                       input logic [7:0] all, input logic [7:0] magic,
                                       input bit stalled, input bit clr);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (a[i] | magic[i]) & x[i] & all[i];
    if (stalled && clr) r[4] = 1'b0;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_both(input logic [7:0] e0, input logic [7:0] e1, input string req);
    chk(d0 === 1'b1 && d1 === 1'b1, "R3", {d0, d1}, 2'b11);
    chk(a0 === e0, req, a0, e0);
    chk(n0 === e0[7] && z0 === (e0 == 8'h00), "R6", {n0, z0}, {e0[7], e0 == 8'h00});
    chk(a1 === e1, {req, "/R9"}, a1, e1);
    chk(n1 === e1[7] && z1 === (e1 == 8'h00), "R6", {n1, z1}, {e1[7], e1 == 8'h00});
  endtask

  task automatic run_op(input logic [7:0] a, input bit lda, input logic [7:0] x, input bit ldx,
                        input int ns, input logic [3:0][7:0] sv, input logic [7:0] op,
                        input string req);
    logic [7:0] all, e0, e1;
    @(negedge clk);
    start = 1'b1; a_wr = lda; a_wdata = a; x_wr = ldx; x_wdata = x; rdy = 1'b1;
    if (lda) begin ra0 = a; ra1 = a; end
    if (ldx) rx = x;
    @(negedge clk);
    start = 1'b0; a_wr = 1'b0; x_wr = 1'b0;
    all = 8'hFF;
    for (int s = 0; s < ns; s++) begin
      rdy = 1'b0; data_in = sv[s]; all = all & sv[s];
      @(negedge clk);
      chk(d0 === 1'b0 && a0 === ra0, "R8", a0, ra0);
    end
    rdy = 1'b1; data_in = op; all = all & op;
    @(negedge clk);
    e0 = model(ra0, rx, all, 8'hEE, ns > 0, 1'b1);
    e1 = model(ra1, rx, all, 8'h00, ns > 0, 1'b0);
    check_both(e0, e1, req);
    ra0 = e0; ra1 = e1;
    data_in = 8'h00;
    @(negedge clk);
    chk(d0 === 1'b0 && d1 === 1'b0, "R3", {d0, d1}, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [3:0][7:0] sv;
    logic [7:0] e0, e1, ra, rxv, rop;
    int n;
    ra0 = 8'h00; ra1 = 8'h00; rx = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(a0 === 8'h00 && a1 === 8'h00, "R1", a0, 0);
    chk(n0 === 1'b0 && z0 === 1'b0 && d0 === 1'b0, "R1", {n0, z0, d0}, 0);
    // R1: X cleared by reset -> result 0, Z set
    run_op(8'hFF, 1'b1, 8'h00, 1'b0, 0, '0, 8'hFF, "R1");

    // R2: vector table, no stall
    foreach (VEC[i]) begin
      run_op(VEC[i][31:24], 1'b1, VEC[i][23:16], 1'b1, 0, '0, VEC[i][15:8], "R2");
      chk(a0 === VEC[i][7:0], "R2", a0, VEC[i][7:0]);
    end

    // R4/R5: directed stall, stray 0xF7 ANDed in, bit 4 stripped only in variant 0
    sv = '0; sv[0] = 8'hF7;
    run_op(8'hFF, 1'b1, 8'hFF, 1'b1, 1, sv, 8'hFF, "R4");
    chk(a0 === 8'hE7, "R5", a0, 8'hE7);
    chk(a1 === 8'hF7, "R5", a1, 8'hF7);

    // R2/R9: random sweep without stalls
    for (int k = 0; k < 1500; k++) begin
      ra = 8'($urandom); rxv = 8'($urandom); rop = 8'($urandom);
      run_op(ra, 1'b1, rxv, 1'b1, 0, '0, rop, "R2");
    end

    // R4: random stall lengths and stray bus values
    for (int k = 0; k < 400; k++) begin
      ra = 8'($urandom); rxv = 8'($urandom); rop = 8'($urandom | 32'h0000_00C3);
      n = 1 + ($urandom % 4);
      for (int s = 0; s < 4; s++) sv[s] = 8'($urandom | 32'h0000_0081);
      run_op(ra, 1'b1, rxv, ($urandom % 2) == 0, n, sv, rop, "R4");
    end

    // R7/R8: start and loads during a stall are discarded
    @(negedge clk);
    start = 1'b1; a_wr = 1'b1; a_wdata = 8'hFF; x_wr = 1'b1; x_wdata = 8'hFF;
    @(negedge clk);
    start = 1'b1; a_wr = 1'b1; a_wdata = 8'h00; x_wr = 1'b1; x_wdata = 8'h00;
    rdy = 1'b0; data_in = 8'hFF;
    @(negedge clk);
    chk(a0 === 8'hFF && a1 === 8'hFF, "R8", a1, 8'hFF);
    start = 1'b0; a_wr = 1'b0; x_wr = 1'b0;
    rdy = 1'b1; data_in = 8'h3C;
    @(negedge clk);
    check_both(8'h2C, 8'h3C, "R7");
    ra0 = 8'h2C; ra1 = 8'h3C; rx = 8'hFF;
    @(negedge clk);
    chk(d0 === 1'b0, "R3", d0, 0);
    // X must still be 0xFF: plain op, no X load
    run_op(8'hFF, 1'b1, 8'h00, 1'b0, 0, '0, 8'hFF, "R7");
    chk(a1 === 8'hFF, "R7", a1, 8'hFF);

    finish_run();
  end
endmodule